// File: doc/BRIEF.md
# Single-Clock Buffer with Hysteresis Threshold Flags

This block is a first-in first-out store for 8-bit words, clocked by one clock. A producer presents a word with a write strobe. A consumer raises a read strobe and receives the oldest stored word on the data output one clock later. Strobes that would overflow or underflow the store are refused inside the block, so neither side can corrupt it.

Status comes out as registered signals:
- exact full and empty flags;
- near-full and near-empty flags, which warn one entry before the limit;
- a 5-bit occupancy count.

Two more flags have programmable thresholds, set by parameters. Each has separate set and clear levels, which gives hysteresis. The low-water flag tells a producer to refill. The high-water flag tells it to back off. Both threshold flags track the occupancy with a fixed two-clock lag. Reset is synchronous and active high.

Top module: `sync_fifo_thresh`

## Requirements
- R1: While `rst` is high at a clock edge, the block empties itself. After the edge, `data_count` is 0, `empty`, `almost_empty` and `prog_empty` are 1, `full`, `almost_full` and `prog_full` are 0, and `dout` is 0.
- R2: Words leave in the order they were accepted. An accepted read at edge k places the oldest word on `dout` after edge k. `dout` holds its value when no read is accepted.
- R3: A write is refused when `full` is 1. The count stays unchanged and no stored word is altered.
- R4: A read is refused when `empty` is 1. The count stays unchanged and `dout` keeps its value.
- R5: `data_count` rises by 1 on an edge with only an accepted write. It falls by 1 with only an accepted read. It is unchanged when both are accepted or neither is.
- R6: `full` is 1 exactly when `data_count` equals the depth (16 by default). `empty` is 1 exactly when `data_count` is 0. Both update on the same edge as the count.
- R7: `almost_full` is 1 exactly when `data_count` is at least depth-1. `almost_empty` is 1 exactly when `data_count` is at most 1. Both update on the same edge as the count.
- R8: `prog_empty` sets when the occupancy is at or below `PE_SET` (default 4). It clears when the occupancy is at or above `PE_CLR` (default 6). It holds its value in between. The flag is registered twice, so it follows the occupancy two edges later: a count that reaches `PE_CLR` at edge k clears the flag after edge k+2.
- R9: `prog_full` sets when the occupancy is at or above `PF_SET` (default 12). It clears when the occupancy is at or below `PF_CLR` (default 10). It holds its value in between. It has the same two-edge lag as `prog_empty`.
- R10: When both strobes are high together on an empty buffer, only the write is accepted. When both are high on a full buffer, only the read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| din | input | 8 | Word to store |
| rd_en | input | 1 | Read strobe |
| dout | output | 8 | Word read out, valid one clock after an accepted read |
| full | output | 1 | Buffer holds depth words |
| almost_full | output | 1 | Buffer holds at least depth-1 words |
| empty | output | 1 | Buffer holds no words |
| almost_empty | output | 1 | Buffer holds at most one word |
| data_count | output | 5 | Number of stored words |
| prog_full | output | 1 | High-water flag with hysteresis |
| prog_empty | output | 1 | Low-water flag with hysteresis |

## Verification
A wrong read pointer shows up on `dout` at the first accepted read after the fault, as a word out of sequence. A wrong write pointer shows up later, when the misplaced entry reaches the head of the queue. A miscounted occupancy appears on `data_count`, `full`, `empty` and the near flags on the same edge. Because the threshold flags are registered twice, it reaches them only two edges later. A missing refusal of a write on a full buffer, or of a read on an empty one, moves the count past its limits at once. It also corrupts the sequence seen on `dout` for the rest of the run.

// File: rtl/fifo_thresh_pkg.sv
package fifo_thresh_pkg;

  // Polarity of a hysteresis flag: which side of the band sets it.
  typedef enum logic {
    SET_ON_LOW  = 1'b0,
    SET_ON_HIGH = 1'b1
  } hyst_pol_e;

  // Next value of a hysteresis flag for a given occupancy.
  function automatic logic hyst_next(
    input hyst_pol_e   pol,
    input int unsigned level,
    input int unsigned set_lvl,
    input int unsigned clr_lvl,
    input logic        cur
  );
    logic r;
    r = cur;
    if (pol == SET_ON_LOW) begin
      if (level <= set_lvl)      r = 1'b1;
      else if (level >= clr_lvl) r = 1'b0;
    end else begin
      if (level >= set_lvl)      r = 1'b1;
      else if (level <= clr_lvl) r = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
  parameter int ADDR_W  = 4,
  localparam int CNT_W  = ADDR_W + 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic              rd_req,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  level,
  output logic              is_full,
  output logic              is_empty,
  output logic              near_full,
  output logic              near_empty
);

  // Pointers carry one wrap bit above the address bits.
  logic [ADDR_W:0] wp_q, rp_q;
  logic [ADDR_W:0] wp_d, rp_d;
  logic [CNT_W-1:0] lvl_d;

  // Refusal of overflow and underflow is decided from registered flags.
  assign wr_go = wr_req && !is_full;
  assign rd_go = rd_req && !is_empty;

  always_comb begin
    wp_d  = wp_q + {{ADDR_W{1'b0}}, wr_go};
    rp_d  = rp_q + {{ADDR_W{1'b0}}, rd_go};
    lvl_d = wp_d - rp_d;
  end

  assign wr_addr = wp_q[ADDR_W-1:0];
  assign rd_addr = rp_q[ADDR_W-1:0];

  // All status is registered, computed from the next-state pointers.
  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q       <= '0;
      rp_q       <= '0;
      level      <= '0;
      is_full    <= 1'b0;
      is_empty   <= 1'b1;
      near_full  <= 1'b0;
      near_empty <= 1'b1;
    end else begin
      wp_q       <= wp_d;
      rp_q       <= rp_d;
      level      <= lvl_d;
      is_full    <= (lvl_d == CNT_W'(DEPTH));
      is_empty   <= (lvl_d == '0);
      near_full  <= (lvl_d >= CNT_W'(DEPTH - 1));
      near_empty <= (lvl_d <= CNT_W'(1));
    end
  end

endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ram [DEPTH];

  // Plain write port with no reset, so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // Registered read port; holds its value between reads.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end

endmodule

// File: rtl/hyst_flag.sv
module hyst_flag
  import fifo_thresh_pkg::*;
#(
  parameter int        CNT_W     = 5,
  parameter int        SET_LVL   = 4,
  parameter int        CLR_LVL   = 6,
  parameter hyst_pol_e POL       = SET_ON_LOW,
  parameter int        STAGES    = 2,
  parameter logic      RESET_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] level,
  output logic             flag
);

  logic [STAGES-1:0] pipe;

  // Stage 0 applies the hysteresis band to the occupancy.
  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RESET_VAL;
    else     pipe[0] <= hyst_next(POL, int'(level), SET_LVL, CLR_LVL, pipe[0]);
  end

  // Later stages only delay the decision.
  for (genvar s = 1; s < STAGES; s++) begin : g_dly
    always_ff @(posedge clk) begin
      if (rst) pipe[s] <= RESET_VAL;
      else     pipe[s] <= pipe[s-1];
    end
  end

  assign flag = pipe[STAGES-1];

endmodule

// File: rtl/sync_fifo_thresh.sv
module sync_fifo_thresh
  import fifo_thresh_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int PE_SET    = 4,
  parameter int PE_CLR    = 6,
  parameter int PF_SET    = 12,
  parameter int PF_CLR    = 10,
  parameter int FLAG_LAG  = 2,
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  output logic [DATA_W-1:0] dout,
  output logic              full,
  output logic              almost_full,
  output logic              empty,
  output logic              almost_empty,
  output logic [CNT_W-1:0]  data_count,
  output logic              prog_full,
  output logic              prog_empty
);

  logic              wr_go, rd_go;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  fifo_ptr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (wr_en),
    .rd_req     (rd_en),
    .wr_go      (wr_go),
    .rd_go      (rd_go),
    .wr_addr    (wr_addr),
    .rd_addr    (rd_addr),
    .level      (data_count),
    .is_full    (full),
    .is_empty   (empty),
    .near_full  (almost_full),
    .near_empty (almost_empty)
  );

  fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (wr_addr),
    .wdata (din),
    .re    (rd_go),
    .raddr (rd_addr),
    .rdata (dout)
  );

  hyst_flag #(
    .CNT_W(CNT_W), .SET_LVL(PE_SET), .CLR_LVL(PE_CLR),
    .POL(SET_ON_LOW), .STAGES(FLAG_LAG), .RESET_VAL(1'b1)
  ) u_pe (
    .clk   (clk),
    .rst   (rst),
    .level (data_count),
    .flag  (prog_empty)
  );

  hyst_flag #(
    .CNT_W(CNT_W), .SET_LVL(PF_SET), .CLR_LVL(PF_CLR),
    .POL(SET_ON_HIGH), .STAGES(FLAG_LAG), .RESET_VAL(1'b0)
  ) u_pf (
    .clk   (clk),
    .rst   (rst),
    .level (data_count),
    .flag  (prog_full)
  );

endmodule

// File: rtl/sync_fifo_thresh_chk.sv
module sync_fifo_thresh_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int PE_CLR = 6,
  parameter int PF_SET = 12,
  localparam int CNT_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] dout,
  input logic              full,
  input logic              almost_full,
  input logic              empty,
  input logic [CNT_W-1:0]  data_count,
  input logic              prog_full,
  input logic              prog_empty
);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> $stable(data_count));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_en) |=> ($stable(dout) && data_count == '0));

  p_count_up_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !full && !(rd_en && !empty)) |=>
      (int'(data_count) == int'($past(data_count)) + 1));

  p_full_level_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> (int'(data_count) == DEPTH));

  p_empty_level_r6: assert property (@(posedge clk) disable iff (rst)
    empty |-> (data_count == '0));

  p_near_full_r7: assert property (@(posedge clk) disable iff (rst)
    almost_full |-> (int'(data_count) >= DEPTH - 1));

  p_pe_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(prog_empty) |-> (int'($past(data_count, 2)) >= PE_CLR));

  p_pf_set_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_full) |-> (int'($past(data_count, 2)) >= PF_SET));

endmodule

bind sync_fifo_thresh sync_fifo_thresh_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PE_CLR(PE_CLR), .PF_SET(PF_SET)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .dout        (dout),
  .full        (full),
  .almost_full (almost_full),
  .empty       (empty),
  .data_count  (data_count),
  .prog_full   (prog_full),
  .prog_empty  (prog_empty)
);

// File: tb/sim_sync_fifo_thresh.sv
`timescale 1ns / 1ps
module sim_sync_fifo_thresh;

  localparam int DEPTH  = 16;
  localparam int PE_SET = 4;
  localparam int PE_CLR = 6;
  localparam int PF_SET = 12;
  localparam int PF_CLR = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       full, almost_full, empty, almost_empty, prog_full, prog_empty;
  logic [4:0] data_count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // Scoreboard state
  logic [7:0] sb_q[$];
  int         m_cnt = 0;
  logic       m_pe_h = 1, m_pe = 1, m_pf_h = 0, m_pf = 0;
  logic       chk_pending = 0;
  logic [7:0] chk_val = '0;
  logic [7:0] m_dout = '0;
  logic [7:0] dval = 8'h30;

  always #5 clk = ~clk;

  sync_fifo_thresh u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout), .full(full), .almost_full(almost_full), .empty(empty),
    .almost_empty(almost_empty), .data_count(data_count),
    .prog_full(prog_full), .prog_empty(prog_empty)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compares read data one clock after an accepted read (R2).
  always @(negedge clk) begin
    if (chk_pending) begin
      check("R2 read order", int'(dout), int'(chk_val));
      chk_pending = 0;
    end
  end

  task automatic check_status();
    check("R5 count", int'(data_count), m_cnt);
    check("R6 full", int'(full), int'(m_cnt == DEPTH));
    check("R6 empty", int'(empty), int'(m_cnt == 0));
    check("R7 almost_full", int'(almost_full), int'(m_cnt >= DEPTH - 1));
    check("R7 almost_empty", int'(almost_empty), int'(m_cnt <= 1));
    check("R8 prog_empty", int'(prog_empty), int'(m_pe));
    check("R9 prog_full", int'(prog_full), int'(m_pf));
  endtask

  // Driver: one clock of stimulus; expected items go into the queue.
  task automatic step(input logic w, input logic r);
    logic wa, ra;
    int   old_cnt;
    @(negedge clk);
    wr_en = w; rd_en = r; din = dval;
    wa = w && (m_cnt < DEPTH);
    ra = r && (m_cnt > 0);
    @(posedge clk);
    #1;
    old_cnt = m_cnt;
    m_pe = m_pe_h;
    m_pf = m_pf_h;
    if (old_cnt <= PE_SET) m_pe_h = 1; else if (old_cnt >= PE_CLR) m_pe_h = 0;
    if (old_cnt >= PF_SET) m_pf_h = 1; else if (old_cnt <= PF_CLR) m_pf_h = 0;
    if (ra) begin
      chk_val = sb_q.pop_front();
      m_dout = chk_val;
      chk_pending = 1;
    end
    if (wa) begin
      sb_q.push_back(dval);
      dval = dval + 8'd1;
    end
    m_cnt = m_cnt + (wa ? 1 : 0) - (ra ? 1 : 0);
    #1;
    check_status();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    check("R1 count", int'(data_count), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 almost_empty", int'(almost_empty), 1);
    check("R1 prog_empty", int'(prog_empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 almost_full", int'(almost_full), 0);
    check("R1 prog_full", int'(prog_full), 0);
    check("R1 dout", int'(dout), 0);

    // R4: reads on empty buffer have no effect
    for (int i = 0; i < 3; i++) begin
      step(0, 1);
      check("R4 dout held", int'(dout), 0);
      check("R4 count held", int'(data_count), 0);
    end

    // R10: both strobes on empty -> write only
    step(1, 1);
    check("R10 write-only on empty", int'(data_count), 1);

    // Fill to full, exercising R6/R7/R8/R9 at each edge
    while (m_cnt < DEPTH) step(1, 0);
    step(0, 0);
    step(0, 0);

    // R3: writes on full buffer refused
    step(1, 0);
    check("R3 count held", int'(data_count), DEPTH);
    step(1, 0);
    check("R3 full held", int'(full), 1);

    // R10: both strobes on full -> read only
    step(1, 1);
    check("R10 read-only on full", int'(data_count), DEPTH - 1);

    // Drain through the hysteresis bands, with idle gaps
    while (m_cnt > 8) step(0, 1);
    step(0, 0);
    step(0, 0);
    while (m_cnt > 5) step(0, 1);
    step(0, 0);
    step(0, 0);
    step(0, 1);
    step(0, 0);
    step(0, 0);

    // R5: simultaneous traffic keeps count steady
    for (int i = 0; i < 6; i++) begin
      step(1, 1);
      check("R5 steady on both", int'(data_count), 4);
    end

    // Refill slowly to see prog_empty clear two edges after reaching PE_CLR
    step(1, 0);
    step(1, 0);
    step(0, 0);
    step(0, 0);
    step(0, 0);

    // Drain to empty, then one more refused read
    while (m_cnt > 0) step(0, 1);
    step(0, 1);
    check("R4 dout held after drain", int'(dout), int'(m_dout));
    step(0, 0);
    step(0, 0);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule